// File: doc/BRIEF.md
# Super-Tiled Texture Address Generator

This block turns pixel coordinates into byte addresses for a surface stored in a two-level tiled layout. The smallest unit is a 4x4 pixel tile whose pixels are stored row by row. In the super-tiled layouts, tiles are grouped into blocks two tiles wide and four tiles high. Eight such groups across and four down form a 64x64 pixel super-tile. Every level is in row-major order: pixels within a tile, tiles within a group, groups within a super-tile, and super-tiles across the surface. The plain tiled layout skips the group and super-tile levels and lays the tiles out in row-major order across the whole surface.

Each layout also has a dual-pipe split form. In that form, tiles with an even linear tile index are placed relative to a first base address and tiles with an odd index relative to a second one. The offset from either base is computed from the tile index shifted right by one, so all offsets are halved.

Addresses come from one of two sources. The block can take one coordinate per beat on a valid/ready input, or it can walk the whole configured surface by itself in raster order. Results leave through a registered valid/ready output.

Top module: `sttile_addr_gen`

## Requirements
- R1: After reset, outValid is 0 and inReady is 1.
- R2: The layout code cfgMode is interpreted as follows. Bit 0 = 1 selects the super-tiled layout and bit 1 = 1 selects the split form. In plain tiled mode (cfgMode=0), the tile index is (y/4)*(16*widthSt) + x/4, the in-tile index is (y%4)*4 + x%4, and the address is base0 + (tileIndex*16 + inTile)*bytesPerPixel.
- R3: In super-tiled mode (cfgMode=1), the tile index is ((y/64)*widthSt + x/64)*256 + group*8 + tileInGroup. Here tx=(x/4)%16 and ty=(y/4)%16, group = (ty/4)*8 + tx/2, and tileInGroup = (ty%4)*2 + tx%2. The address is formed from this tile index as in R2.
- R4: In the split modes (cfgMode=2 plain, 3 super), a tile with an even index uses base0 and a tile with an odd index uses base1. The offset is ((tileIndex>>1)*16 + inTile)*bytesPerPixel.
- R5: cfgBppLog2 codes 0, 1 and 2 select 1, 2 and 4 bytes per pixel. Code 3 is taken as 4 bytes.
- R6: A coordinate with x >= 64*widthSt or y >= 64*heightSt gives a beat with outErr=1 and outAddr=0.
- R7: A coordinate presented in cycle n while inReady=1 and outReady=1 appears on the output in cycle n+2. The output is not valid in cycle n+1.
- R8: While outReady is 0, outValid, outAddr and outErr hold their values. Once both stages are full, inReady drops. No beat is lost or reordered.
- R9: A walkGo pulse while idle, with a non-zero surface size, emits every pixel of the surface in raster order (x fastest). inReady stays 0 during the walk.
- R10: Configuration is captured only when cfgLoad is high while the block is idle (no walk and no beat in flight). A cfgLoad at any other time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgLoad | input | 1 | Capture configuration (honoured only when idle) |
| cfgMode | input | 2 | Layout: bit0 super-tiled, bit1 split |
| cfgBase0 | input | AW | Base address for even tiles / non-split |
| cfgBase1 | input | AW | Base address for odd tiles in split modes |
| cfgBppLog2 | input | 2 | log2 of bytes per pixel |
| cfgWidthSt | input | STW | Surface width in super-tiles |
| cfgHeightSt | input | STW | Surface height in super-tiles |
| walkGo | input | 1 | Start a raster walk of the surface |
| inValid | input | 1 | Coordinate beat valid |
| inReady | output | 1 | Coordinate beat accepted |
| inX | input | STW+6 | Pixel x |
| inY | input | STW+6 | Pixel y |
| outValid | output | 1 | Address beat valid |
| outReady | input | 1 | Downstream accepts address |
| outAddr | output | AW | Byte address (0 on error) |
| outErr | output | 1 | Coordinate was outside the surface |

## Verification
A coordinate accepted in cycle n yields its address in cycle n+2. The bench therefore drives each beat at a falling edge, checks that outValid is still low one falling edge later, and reads the result at the falling edge after that.

In the stall and walk scenarios, the bench samples only at falling edges. An output beat counts as consumed only when outValid and outReady are both high at that falling edge. Each consumed beat is compared in order against addresses computed in the bench from the layout rules.

// File: rtl/sttile_pkg.sv
package sttile_pkg;
  typedef enum logic [1:0] {
    LAY_TILE        = 2'd0,
    LAY_SUPER       = 2'd1,
    LAY_TILE_SPLIT  = 2'd2,
    LAY_SUPER_SPLIT = 2'd3
  } layout_e;

  typedef struct packed {
    logic cfgTake;   // capture configuration
    logic walkSel;   // stage-1 source is the walker
    logic ld1;       // load stage 1
    logic ld2;       // load output stage
  } strobes_t;
endpackage

// File: rtl/sttile_ctrl.sv
module sttile_ctrl
  import sttile_pkg::*;
#(
  parameter int STW = 6,
  localparam int CW = STW + 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgLoad,
  input  logic           walkGo,
  input  logic           inValid,
  input  logic           outReady,
  input  logic [STW-1:0] widthSt,
  input  logic [STW-1:0] heightSt,
  output logic           inReady,
  output logic           outValid,
  output logic [CW-1:0]  walkX,
  output logic [CW-1:0]  walkY,
  output strobes_t       strb
);
  logic walking, v1, v2;
  logic s1Ready, s2Ready, idle, walkStart;
  logic [CW-1:0] xMax, yMax;

  assign s2Ready   = !v2 || outReady;
  assign s1Ready   = !v1 || s2Ready;
  assign idle      = !walking && !v1 && !v2;
  assign inReady   = !walking && s1Ready;
  assign walkStart = walkGo && idle && (widthSt != '0) && (heightSt != '0);
  assign xMax      = {widthSt, 6'b0} - CW'(1);
  assign yMax      = {heightSt, 6'b0} - CW'(1);
  assign outValid  = v2;

  always_comb begin
    strb.cfgTake = cfgLoad && idle;
    strb.walkSel = walking;
    strb.ld1     = s1Ready && (walking || inValid);
    strb.ld2     = v1 && s2Ready;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
    end else begin
      if (s1Ready) v1 <= walking || inValid;
      if (s2Ready) v2 <= v1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      walking <= 1'b0;
      walkX   <= '0;
      walkY   <= '0;
    end else if (walkStart) begin
      walking <= 1'b1;
      walkX   <= '0;
      walkY   <= '0;
    end else if (walking && s1Ready) begin
      if (walkX == xMax) begin
        walkX <= '0;
        if (walkY == yMax) walking <= 1'b0;
        else walkY <= walkY + CW'(1);
      end else begin
        walkX <= walkX + CW'(1);
      end
    end
  end

  // R9: external coordinates are never accepted during a walk
  p_walk_blocks_in_r9: assert property (@(posedge clk) disable iff (!rstN)
    walking |-> !inReady);
endmodule

// File: rtl/sttile_datapath.sv
module sttile_datapath
  import sttile_pkg::*;
#(
  parameter int AW  = 32,
  parameter int STW = 6,
  localparam int CW  = STW + 6,
  localparam int TIW = 2 * STW + 8,
  localparam int OFW = TIW + 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobes_t       strb,
  input  logic [1:0]     cfgMode,
  input  logic [AW-1:0]  cfgBase0,
  input  logic [AW-1:0]  cfgBase1,
  input  logic [1:0]     cfgBppLog2,
  input  logic [STW-1:0] cfgWidthSt,
  input  logic [STW-1:0] cfgHeightSt,
  input  logic [CW-1:0]  inX,
  input  logic [CW-1:0]  inY,
  input  logic [CW-1:0]  walkX,
  input  logic [CW-1:0]  walkY,
  output logic [STW-1:0] widthSt,
  output logic [STW-1:0] heightSt,
  output logic [AW-1:0]  outAddr,
  output logic           outErr
);
  layout_e        modeReg;
  logic [AW-1:0]  base0Reg, base1Reg;
  logic [1:0]     bppReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= LAY_TILE;
      base0Reg <= '0;
      base1Reg <= '0;
      bppReg   <= 2'd0;
      widthSt  <= '0;
      heightSt <= '0;
    end else if (strb.cfgTake) begin
      modeReg  <= layout_e'(cfgMode);
      base0Reg <= cfgBase0;
      base1Reg <= cfgBase1;
      bppReg   <= (cfgBppLog2 == 2'd3) ? 2'd2 : cfgBppLog2;
      widthSt  <= cfgWidthSt;
      heightSt <= cfgHeightSt;
    end
  end

  // stage 1: coordinate to tile index and in-tile index
  logic [CW-1:0]    px, py;
  logic             isSuper, isSplit, errC;
  logic [TIW-1:0]   flatIdx, superIdx, tileIdx;
  logic [2*STW-1:0] stIdx;
  logic [3:0]       tx, ty, inTile;
  logic [4:0]       group;
  logic [2:0]       tig;
  logic [OFW-1:0]   offPix;

  assign px      = strb.walkSel ? walkX : inX;
  assign py      = strb.walkSel ? walkY : inY;
  assign isSuper = modeReg[0];
  assign isSplit = modeReg[1];
  assign errC    = (px >= {widthSt, 6'b0}) || (py >= {heightSt, 6'b0});
  assign inTile  = {py[1:0], px[1:0]};

  assign flatIdx = TIW'(py[CW-1:2]) * TIW'({widthSt, 4'b0}) + TIW'(px[CW-1:2]);

  assign tx       = px[5:2];
  assign ty       = py[5:2];
  assign group    = {ty[3:2], tx[3:1]};
  assign tig      = {ty[1:0], tx[0]};
  assign stIdx    = (2*STW)'(py[CW-1:6]) * (2*STW)'(widthSt) + (2*STW)'(px[CW-1:6]);
  assign superIdx = {stIdx, group, tig};

  assign tileIdx = isSuper ? superIdx : flatIdx;
  assign offPix  = isSplit ? {1'b0, tileIdx[TIW-1:1], inTile} : {tileIdx, inTile};

  logic [OFW-1:0] r1Off;
  logic           r1Pipe, r1Err;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      r1Off  <= '0;
      r1Pipe <= 1'b0;
      r1Err  <= 1'b0;
    end else if (strb.ld1) begin
      r1Off  <= offPix;
      r1Pipe <= isSplit && tileIdx[0];
      r1Err  <= errC;
    end
  end

  // stage 2: scale by pixel size and add the pipe base
  logic [OFW+1:0] byteOff;
  logic [AW-1:0]  addrC;

  assign byteOff = (OFW + 2)'(r1Off) << bppReg;
  assign addrC   = (r1Pipe ? base1Reg : base0Reg) + AW'(byteOff);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outAddr <= '0;
      outErr  <= 1'b0;
    end else if (strb.ld2) begin
      outAddr <= r1Err ? '0 : addrC;
      outErr  <= r1Err;
    end
  end

  // R5: four-byte pixels keep the base alignment in the low address bits
  p_align_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.ld2 && !r1Err && !r1Pipe && (bppReg == 2'd2) && !strb.cfgTake
      |=> outAddr[1:0] == base0Reg[1:0]);
endmodule

// File: rtl/sttile_addr_gen.sv
module sttile_addr_gen
  import sttile_pkg::*;
#(
  parameter int AW  = 32,
  parameter int STW = 6,
  localparam int CW = STW + 6
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgLoad,
  input  logic [1:0]     cfgMode,
  input  logic [AW-1:0]  cfgBase0,
  input  logic [AW-1:0]  cfgBase1,
  input  logic [1:0]     cfgBppLog2,
  input  logic [STW-1:0] cfgWidthSt,
  input  logic [STW-1:0] cfgHeightSt,
  input  logic           walkGo,
  input  logic           inValid,
  output logic           inReady,
  input  logic [CW-1:0]  inX,
  input  logic [CW-1:0]  inY,
  output logic           outValid,
  input  logic           outReady,
  output logic [AW-1:0]  outAddr,
  output logic           outErr
);
  strobes_t       strb;
  logic [CW-1:0]  walkX, walkY;
  logic [STW-1:0] widthSt, heightSt;

  sttile_ctrl #(.STW(STW)) ctrl_i (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .walkGo(walkGo),
    .inValid(inValid), .outReady(outReady),
    .widthSt(widthSt), .heightSt(heightSt),
    .inReady(inReady), .outValid(outValid),
    .walkX(walkX), .walkY(walkY), .strb(strb)
  );

  sttile_datapath #(.AW(AW), .STW(STW)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgMode(cfgMode), .cfgBase0(cfgBase0), .cfgBase1(cfgBase1),
    .cfgBppLog2(cfgBppLog2), .cfgWidthSt(cfgWidthSt), .cfgHeightSt(cfgHeightSt),
    .inX(inX), .inY(inY), .walkX(walkX), .walkY(walkY),
    .widthSt(widthSt), .heightSt(heightSt),
    .outAddr(outAddr), .outErr(outErr)
  );

  // R8: a stalled output beat is held unchanged
  p_hold_stall_r8: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outAddr) && $stable(outErr));

  // R6: an error beat carries no address
  p_err_no_addr_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid && outErr |-> outAddr == '0);
endmodule

// File: tb/sttile_addr_gen_tb.sv
module sttile_addr_gen_tb_top;
  localparam int AW = 32;
  localparam int STW = 6;
  localparam int CW = STW + 6;
  localparam logic [31:0] B0 = 32'h1000_0000;
  localparam logic [31:0] B1 = 32'h2000_0000;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgLoad = 0, walkGo = 0, inValid = 0, outReady = 1;
  logic [1:0] cfgMode = 0, cfgBppLog2 = 0;
  logic [AW-1:0] cfgBase0 = B0, cfgBase1 = B1;
  logic [STW-1:0] cfgWidthSt = 0, cfgHeightSt = 0;
  logic [CW-1:0] inX = 0, inY = 0;
  logic inReady, outValid, outErr;
  logic [AW-1:0] outAddr;

  int checks = 0, failures = 0;
  bit doneFlag = 0;

  always #5 clk = ~clk;

  sttile_addr_gen #(.AW(AW), .STW(STW)) dut_i (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic [1:0]  bpp;
    logic [11:0] x;
    logic [11:0] y;
    logic [31:0] addr;
    logic        err;
  } vec_t;

  // surface 2x1 super-tiles, base0 = 0x1000_0000, base1 = 0x2000_0000
  localparam vec_t VECS [12] = '{
    '{2'd0, 2'd0, 12'd5,   12'd6,  32'h1000_0219, 1'b0},  // R2
    '{2'd0, 2'd2, 12'd127, 12'd63, 32'h1000_7FFC, 1'b0},  // R2 R5
    '{2'd1, 2'd0, 12'd5,   12'd6,  32'h1000_0039, 1'b0},  // R3
    '{2'd1, 2'd1, 12'd70,  12'd20, 32'h1000_2864, 1'b0},  // R3 R5
    '{2'd1, 2'd2, 12'd40,  12'd50, 32'h1000_3A20, 1'b0},  // R3
    '{2'd2, 2'd0, 12'd5,   12'd6,  32'h2000_0109, 1'b0},  // R4 odd tile
    '{2'd2, 2'd1, 12'd8,   12'd0,  32'h1000_0020, 1'b0},  // R4 even tile
    '{2'd3, 2'd2, 12'd70,  12'd20, 32'h2000_2848, 1'b0},  // R4 odd tile
    '{2'd3, 2'd0, 12'd40,  12'd50, 32'h1000_0748, 1'b0},  // R4 even tile
    '{2'd0, 2'd0, 12'd128, 12'd0,  32'h0000_0000, 1'b1},  // R6 x edge
    '{2'd1, 2'd0, 12'd0,   12'd64, 32'h0000_0000, 1'b1},  // R6 y edge
    '{2'd0, 2'd3, 12'd5,   12'd6,  32'h1000_0864, 1'b0}   // R5 code 3
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model(input int mode, input int bpp, input int x, input int y,
                                        input int w, input int h, input logic [31:0] b0, input logic [31:0] b1);
    int tIdx, inT, bytes, pix;
    bit odd;
    if (x >= 64 * w || y >= 64 * h) return 32'h0;
    bytes = (bpp == 3) ? 4 : (1 << bpp);
    inT = (y % 4) * 4 + (x % 4);
    if (mode % 2 == 1) begin
      int txx = (x / 4) % 16;
      int tyy = (y / 4) % 16;
      tIdx = ((y / 64) * w + x / 64) * 256 + ((tyy / 4) * 8 + txx / 2) * 8 + (tyy % 4) * 2 + txx % 2;
    end else begin
      tIdx = (y / 4) * (16 * w) + x / 4;
    end
    odd = (mode >= 2) && (tIdx % 2 == 1);
    if (mode >= 2) tIdx = tIdx / 2;
    pix = tIdx * 16 + inT;
    return (odd ? b1 : b0) + 32'(pix * bytes);
  endfunction

  task automatic loadCfg(input logic [1:0] m, input logic [1:0] b, input logic [31:0] a0,
                         input logic [31:0] a1, input int w, input int h);
    @(negedge clk);
    cfgMode = m; cfgBppLog2 = b; cfgBase0 = a0; cfgBase1 = a1;
    cfgWidthSt = STW'(w); cfgHeightSt = STW'(h); cfgLoad = 1;
    @(negedge clk);
    cfgLoad = 0;
  endtask

  // drive one beat at a falling edge; result read two cycles later (R7)
  task automatic sendOne(input int x, input int y, output logic v1, output logic v2,
                         output logic [31:0] a, output logic e);
    @(negedge clk);
    inX = CW'(x); inY = CW'(y); inValid = 1;
    @(negedge clk);
    inValid = 0;
    v1 = outValid;
    @(negedge clk);
    v2 = outValid; a = outAddr; e = outErr;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0x%08h expected=0x%08h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic v1, v2, e;
    logic [31:0] a;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(outValid == 0, "R1 outValid after reset", 32'(outValid), 0);
    check(inReady == 1, "R1 inReady after reset", 32'(inReady), 1);

    // vector table: R2 R3 R4 R5 R6 with R7 timing on every beat
    for (int i = 0; i < 12; i++) begin
      loadCfg(VECS[i].mode, VECS[i].bpp, B0, B1, 2, 1);
      sendOne(int'(VECS[i].x), int'(VECS[i].y), v1, v2, a, e);
      check(v1 == 0, $sformatf("R7 vec%0d early valid", i), 32'(v1), 0);
      check(v2 == 1, $sformatf("R7 vec%0d valid at n+2", i), 32'(v2), 1);
      check(a == VECS[i].addr, $sformatf("vec%0d addr", i), a, VECS[i].addr);
      check(e == VECS[i].err, $sformatf("vec%0d err (R6)", i), 32'(e), 32'(VECS[i].err));
    end

    // R8: stall with three beats queued
    begin
      int xs[3] = '{5, 128, 8};
      int ys[3] = '{6, 0, 0};
      logic [31:0] expA[3] = '{32'h1000_0219, 32'h0, 32'h1000_0020};
      int sent = 0, got = 0, guard = 0;
      logic firstAddr;
      loadCfg(2'd0, 2'd0, B0, B1, 2, 1);
      @(negedge clk);
      outReady = 0;
      inX = CW'(xs[0]); inY = CW'(ys[0]); inValid = 1;
      @(negedge clk);                       // beat0 accepted
      inX = CW'(xs[1]); inY = CW'(ys[1]);
      @(negedge clk);                       // beat1 accepted
      inX = CW'(xs[2]); inY = CW'(ys[2]);
      check(inReady == 0, "R8 inReady low when full", 32'(inReady), 0);
      repeat (3) @(negedge clk);
      check(outValid == 1 && outAddr == expA[0], "R8 held beat", outAddr, expA[0]);
      outReady = 1;
      sent = 2;
      firstAddr = 1'b0;
      while (got < 3 && guard < 20) begin
        logic acc;
        acc = inValid && inReady;
        if (outValid) begin
          check(outAddr == expA[got], $sformatf("R8 order beat%0d", got), outAddr, expA[got]);
          got++;
        end
        @(negedge clk);
        if (acc) begin inValid = 0; sent++; end
        guard++;
      end
      check(got == 3 && sent == 3, "R8 beat count", 32'(got), 3);
    end

    // R9 walk with R10 ignored load during the walk
    begin
      int beat = 0, bad = 0, cyc = 0;
      logic [31:0] firstBad = 0, firstExp = 0;
      loadCfg(2'd1, 2'd1, B0, B1, 1, 1);
      @(negedge clk);
      walkGo = 1;
      @(negedge clk);
      walkGo = 0;
      check(inReady == 0, "R9 inReady low while walking", 32'(inReady), 0);
      cfgBase0 = 32'h3000_0000; cfgLoad = 1;
      @(negedge clk);
      cfgLoad = 0;
      while (beat < 4096 && cyc < 20000) begin
        outReady = (cyc % 3 != 2);
        if (outValid && outReady) begin
          logic [31:0] ex;
          ex = model(1, 1, beat % 64, beat / 64, 1, 1, B0, B1);
          if (outAddr !== ex || outErr !== 1'b0) begin
            if (bad == 0) begin firstBad = outAddr; firstExp = ex; end
            bad++;
          end
          beat++;
        end
        @(negedge clk);
        cyc++;
      end
      outReady = 1;
      check(beat == 4096, "R9 walk beat count", 32'(beat), 4096);
      check(bad == 0, "R9 walk raster addresses", firstBad, firstExp);
      repeat (4) @(negedge clk);
      check(inReady == 1 && outValid == 0, "R9 idle after walk", 32'(inReady), 1);
      sendOne(5, 6, v1, v2, a, e);
      check(a == 32'h1000_0072, "R10 load during walk ignored", a, 32'h1000_0072);
    end

    doneFlag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule